// File: doc/BRIEF.md
# Accumulating Integrator with Coherent Readout

This block sums a stream of signed samples into a wide accumulator and counts the samples it has added. A bus master can poll the running sum at any time. Reading the running sum also copies the sample count into a separate register, so reading the sum first and the count second always gives a matching pair. The count register keeps its old value until the next read of the sum.

An external trigger pulse marks an output update. The update copies the running sum into an output register, sets a status flag and can raise an interrupt and a DMA request. If an update arrives before the previous one has been read, the block flags an overrun. Internal signed-overflow and counter-wrap conditions are moved into sticky status bits on each update or each read of the running sum.

The integrator is cleared by system reset, by a soft-reset command bit, by a self-clearing zero command bit, or by one of several hardware zero inputs that a select field picks. A zero clears the sum, the counter and the internal overflow state. It leaves the count register and the sticky flags as they are. The register port is a simple single-cycle interface. Read data is combinational from the address, and any side effect of a read takes effect at the clock edge.

Top module: `acc_integrator`

## Requirements
- R1: Each cycle with `smp_vld` high and no zero or soft reset adds the sign-extended `smp_data` to the 32-bit signed sum (wrapping) and increments the 16-bit sample counter (wrapping). Address 3 reads the sum as it stands before that cycle's edge.
- R2: A `trig_in` pulse copies the sum into the output register at address 2 and sets status bit 0. `irq_update` is high while status bit 0 and control bit 0 (update interrupt enable) are both set.
- R3: An update while the previous one is unconsumed sets status bit 1 (overrun). A read of address 2 consumes an update, and a read in the same cycle as a new trigger consumes the old one without an overrun. `irq_error` is high while status bit 1 and control bit 2 (error interrupt enable) are both set.
- R4: An update with control bit 1 (DMA enable) set raises `dma_req`. It stays high until `dma_ack` or a read of address 2, and a new update in the same cycle wins over the clear.
- R5: A read of address 3 loads the sample counter, as it stands before that edge, into the count register at address 4 (zero-extended). Nothing else except reset changes that register.
- R6: An addition whose operands have equal signs and whose result has the opposite sign marks an internal signed overflow. A counter wrap from 0xFFFF marks an internal count overflow. Each update or read of address 3 ORs these into sticky status bits 2 and 3, and neither sets a sticky bit earlier.
- R7: Writing control bit 3 as 1 zeroes the sum, the counter and the internal overflow state, and a sample in that cycle is dropped. The count register and sticky bits are kept. Bit 3 always reads 0.
- R8: Control bits [6:5] select the hardware zero source: 0 disables it and value k uses `zero_in[k-1]`. A pulse on an unselected input has no effect.
- R9: Writing control bit 4 as 1, or `rst_n` low, clears the sum, the counter, the internal overflow state, the count register, the output register, all status bits, the pending update and `dma_req`. A soft reset keeps the enables and the select field written in the same cycle. Bit 4 reads 0.
- R10: Status bits clear when a 1 is written to them at address 1. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed sample |
| trig_in | input | 1 | Output update pulse |
| zero_in | input | 2 | Hardware zero pulses |
| dma_ack | input | 1 | Clears the DMA request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_update | output | 1 | Update interrupt |
| irq_error | output | 1 | Overrun interrupt |
| dma_req | output | 1 | DMA request |

## Verification
Two pairs of functions can fall in the same cycle, and both matter here. A trigger can arrive in the same cycle as a read of the output register, and a sample can be added in the same cycle as a read of the running sum. The bench drives these collisions on purpose in a directed phase, and by chance in a long random phase. A behavioural reference model judges each cycle. For the first collision it expects no overrun and the new value to stay pending. For the second it expects the pre-sample sum and the pre-sample count to be returned as a matching pair.

// File: rtl/acc_integrator_pkg.sv
`timescale 1ns/1ps
package acc_integrator_pkg;
   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
   localparam logic [REG_AW-1:0] A_STAT = 3'd1;
   localparam logic [REG_AW-1:0] A_OUT  = 3'd2;
   localparam logic [REG_AW-1:0] A_CUR  = 3'd3;
   localparam logic [REG_AW-1:0] A_CNT  = 3'd4;
   // control bit positions
   localparam int C_INT  = 0;
   localparam int C_DMA  = 1;
   localparam int C_ERR  = 2;
   localparam int C_SWZ  = 3;
   localparam int C_SRST = 4;
   localparam int C_ZSEL = 5;
   // status bit positions
   localparam int S_UPD = 0;
   localparam int S_OVR = 1;
   localparam int S_SOV = 2;
   localparam int S_COV = 3;
   localparam int ST_W  = 4;
endpackage

// File: rtl/acc_zsel.sv
`timescale 1ns/1ps
module acc_zsel #(
   parameter int ZSRC   = 2,
   parameter int ZSEL_W = 2
) (
   input  logic [ZSRC-1:0]   zero_in,
   input  logic [ZSEL_W-1:0] sel,
   output logic              hw_zero
);
   logic [ZSRC-1:0] hit;

   for (genvar k = 0; k < ZSRC; k++) begin : g_src
      assign hit[k] = zero_in[k] && (sel == ZSEL_W'(k + 1));
   end

   assign hw_zero = |hit;
endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core #(
   parameter int SAMP_W = 24,
   parameter int ACC_W  = 32,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp_vld,
   input  logic [SAMP_W-1:0] smp,
   output logic [ACC_W-1:0] acc_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             sov_q,
   output logic             cov_q
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W-1:0] sext;
   logic [ACC_W-1:0] sum;
   logic             add_ovf;
   logic             cnt_wrap;

   if (SAMP_W == ACC_W) begin : g_same_w
      assign sext = smp;
   end else begin : g_ext_w
      assign sext = {{(ACC_W - SAMP_W){smp[SAMP_W-1]}}, smp};
   end

   assign sum      = acc_q + sext;
   assign add_ovf  = (acc_q[MSB] == sext[MSB]) && (sum[MSB] != acc_q[MSB]);
   assign cnt_wrap = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
         sov_q <= 1'b0;
         cov_q <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         cnt_q <= '0;
         sov_q <= 1'b0;
         cov_q <= 1'b0;
      end else if (smp_vld) begin
         acc_q <= sum;
         cnt_q <= cnt_q + 1'b1;
         sov_q <= sov_q | add_ovf;
         cov_q <= cov_q | cnt_wrap;
      end
   end
endmodule

// File: rtl/acc_snap.sv
`timescale 1ns/1ps
module acc_snap
   import acc_integrator_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             trig,
   input  logic             rd_out,
   input  logic             rd_cur,
   input  logic             ack,
   input  logic             dma_en,
   input  logic [ST_W-1:0]  st_clr,
   input  logic [ACC_W-1:0] acc,
   input  logic [CNT_W-1:0] cnt,
   input  logic             sov_i,
   input  logic             cov_i,
   output logic [ACC_W-1:0] out_q,
   output logic [CNT_W-1:0] curcnt_q,
   output logic [ST_W-1:0]  status_q,
   output logic             dma_q,
   output logic             pend_q
);
   logic [ST_W-1:0] st_set;
   logic            harvest;

   assign harvest = trig || rd_cur;

   always_comb begin
      st_set        = '0;
      st_set[S_UPD] = trig;
      st_set[S_OVR] = trig && pend_q && !rd_out;
      st_set[S_SOV] = harvest && sov_i;
      st_set[S_COV] = harvest && cov_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= '0;
         curcnt_q <= '0;
         status_q <= '0;
         dma_q    <= 1'b0;
         pend_q   <= 1'b0;
      end else if (srst) begin
         out_q    <= '0;
         curcnt_q <= '0;
         status_q <= '0;
         dma_q    <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (trig) begin
            out_q  <= acc;
            pend_q <= 1'b1;
         end else if (rd_out) begin
            pend_q <= 1'b0;
         end
         if (rd_cur) curcnt_q <= cnt;
         if (trig && dma_en)       dma_q <= 1'b1;
         else if (ack || rd_out)   dma_q <= 1'b0;
         status_q <= (status_q & ~st_clr) | st_set;
      end
   end
endmodule

// File: rtl/acc_integrator.sv
`timescale 1ns/1ps
module acc_integrator
   import acc_integrator_pkg::*;
#(
   parameter int SAMP_W = 24,
   parameter int ACC_W  = 32,
   parameter int CNT_W  = 16,
   parameter int ZSRC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [SAMP_W-1:0] smp_data,
   input  logic              trig_in,
   input  logic [ZSRC-1:0]   zero_in,
   input  logic              dma_ack,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ACC_W-1:0]  reg_wdata,
   output logic [ACC_W-1:0]  reg_rdata,
   output logic              irq_update,
   output logic              irq_error,
   output logic              dma_req
);
   localparam int ZSEL_W = $clog2(ZSRC + 1);

   if (SAMP_W < 2 || SAMP_W > ACC_W) begin : g_bad_samp
      $error("acc_integrator: SAMP_W must be in 2..ACC_W");
   end
   if (CNT_W < 1 || CNT_W > ACC_W) begin : g_bad_cnt
      $error("acc_integrator: CNT_W must be in 1..ACC_W");
   end
   if (ACC_W < C_ZSEL + ZSEL_W) begin : g_bad_ctrl
      $error("acc_integrator: ACC_W too narrow for the control register");
   end
   if (ZSRC < 1) begin : g_bad_zsrc
      $error("acc_integrator: ZSRC must be at least 1");
   end

   logic              int_en_q, dma_en_q, err_en_q;
   logic [ZSEL_W-1:0] zsel_q;
   logic              wr_ctrl, wr_stat, rd_out, rd_cur;
   logic              sw_zero, srst, hw_zero, core_clr;
   logic [ST_W-1:0]   st_clr;
   logic [ACC_W-1:0]  acc_q, out_q;
   logic [CNT_W-1:0]  cnt_q, curcnt_q;
   logic              sov_q, cov_q, pend_q, dma_q;
   logic [ST_W-1:0]   status_q;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat  = reg_wr && (reg_addr == A_STAT);
   assign rd_out   = reg_rd && (reg_addr == A_OUT);
   assign rd_cur   = reg_rd && (reg_addr == A_CUR);
   assign sw_zero  = wr_ctrl && reg_wdata[C_SWZ];
   assign srst     = wr_ctrl && reg_wdata[C_SRST];
   assign core_clr = sw_zero || hw_zero || srst;
   assign st_clr   = wr_stat ? reg_wdata[ST_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en_q <= 1'b0;
         dma_en_q <= 1'b0;
         err_en_q <= 1'b0;
         zsel_q   <= '0;
      end else if (wr_ctrl) begin
         int_en_q <= reg_wdata[C_INT];
         dma_en_q <= reg_wdata[C_DMA];
         err_en_q <= reg_wdata[C_ERR];
         zsel_q   <= reg_wdata[C_ZSEL +: ZSEL_W];
      end
   end

   acc_zsel #(.ZSRC(ZSRC), .ZSEL_W(ZSEL_W)) u_zsel (
      .zero_in (zero_in),
      .sel     (zsel_q),
      .hw_zero (hw_zero)
   );

   acc_core #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (core_clr),
      .smp_vld (smp_vld),
      .smp     (smp_data),
      .acc_q   (acc_q),
      .cnt_q   (cnt_q),
      .sov_q   (sov_q),
      .cov_q   (cov_q)
   );

   acc_snap #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .trig     (trig_in),
      .rd_out   (rd_out),
      .rd_cur   (rd_cur),
      .ack      (dma_ack),
      .dma_en   (dma_en_q),
      .st_clr   (st_clr),
      .acc      (acc_q),
      .cnt      (cnt_q),
      .sov_i    (sov_q),
      .cov_i    (cov_q),
      .out_q    (out_q),
      .curcnt_q (curcnt_q),
      .status_q (status_q),
      .dma_q    (dma_q),
      .pend_q   (pend_q)
   );

   assign irq_update = status_q[S_UPD] && int_en_q;
   assign irq_error  = status_q[S_OVR] && err_en_q;
   assign dma_req    = dma_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_INT]             = int_en_q;
            reg_rdata[C_DMA]             = dma_en_q;
            reg_rdata[C_ERR]             = err_en_q;
            reg_rdata[C_ZSEL +: ZSEL_W]  = zsel_q;
         end
         A_STAT:  reg_rdata[ST_W-1:0] = status_q;
         A_OUT:   reg_rdata = out_q;
         A_CUR:   reg_rdata = acc_q;
         A_CNT:   reg_rdata = ACC_W'(curcnt_q);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/acc_integrator_chk.sv
`timescale 1ns/1ps
module acc_integrator_chk
   import acc_integrator_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [REG_AW-1:0] reg_addr,
   input logic [ACC_W-1:0]  reg_wdata,
   input logic              trig_in,
   input logic              dma_req,
   input logic [ACC_W-1:0]  acc_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  curcnt_q,
   input logic [ST_W-1:0]   status_q,
   input logic              dma_en_q
);
   logic c_wr_ctrl, c_srst, c_swz, c_rd_cur, c_rd_out, c_clr_sov;

   assign c_wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign c_srst    = c_wr_ctrl && reg_wdata[C_SRST];
   assign c_swz     = c_wr_ctrl && reg_wdata[C_SWZ];
   assign c_rd_cur  = reg_rd && (reg_addr == A_CUR);
   assign c_rd_out  = reg_rd && (reg_addr == A_OUT);
   assign c_clr_sov = reg_wr && (reg_addr == A_STAT) && reg_wdata[S_SOV];

   assert_sw_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      c_swz |=> (acc_q == '0 && cnt_q == '0));

   assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_rd_cur && !c_srst) |=> $stable(curcnt_q));

   assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in && c_rd_out && !status_q[S_OVR] && !c_srst) |=> !status_q[S_OVR]);

   assert_dma_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in && dma_en_q && !c_srst) |=> dma_req);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[S_SOV] && !c_srst && !c_clr_sov) |=> status_q[S_SOV]);

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_srst |=> (acc_q == '0 && curcnt_q == '0 && status_q == '0 && !dma_req));
endmodule

bind acc_integrator acc_integrator_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .trig_in   (trig_in),
   .dma_req   (dma_req),
   .acc_q     (acc_q),
   .cnt_q     (cnt_q),
   .curcnt_q  (curcnt_q),
   .status_q  (status_q),
   .dma_en_q  (dma_en_q)
);

// File: tb/tb_acc_integrator.sv
`timescale 1ns/1ps
module tb_acc_integrator;
   localparam int SW = 24;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam int ZS = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          smp_vld;
   logic [SW-1:0] smp_data;
   logic          trig_in;
   logic [ZS-1:0] zero_in;
   logic          dma_ack;
   logic          reg_wr, reg_rd;
   logic [2:0]    reg_addr;
   logic [AW-1:0] reg_wdata;
   logic [AW-1:0] reg_rdata;
   logic          irq_update, irq_error, dma_req;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   string phase = "R9 reset";

   // reference model state
   int          m_acc;
   logic [15:0] m_cnt, m_curcnt;
   bit          m_sov, m_cov, m_pend, m_dma;
   logic [31:0] m_out;
   logic [3:0]  m_st;
   bit          m_ie, m_de, m_ee;
   logic [1:0]  m_zs;

   always #2 clk = ~clk;

   acc_integrator dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .trig_in(trig_in), .zero_in(zero_in), .dma_ack(dma_ack),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_update(irq_update), .irq_error(irq_error), .dma_req(dma_req)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s [%s]: actual=%0h expected=%0h", tag, phase, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rdata(input logic [2:0] a);
      case (a)
         3'd0: return {25'd0, m_zs, 2'b00, m_ee, m_de, m_ie};
         3'd1: return {28'd0, m_st};
         3'd2: return m_out;
         3'd3: return m_acc;
         3'd4: return {16'd0, m_curcnt};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R7 ctrl";
         3'd1: return "R10 status";
         3'd2: return "R2 output";
         3'd3: return "R1 sum";
         3'd4: return "R5 count";
         default: return "R1 unmapped";
      endcase
   endfunction

   function automatic void model_step();
      bit srst, swz, hwz, zero, rd_out, rd_cur, harvest;
      longint full;
      logic [3:0] clr, set;
      srst   = reg_wr && reg_addr == 0 && reg_wdata[4];
      swz    = reg_wr && reg_addr == 0 && reg_wdata[3];
      hwz    = (m_zs == 1 && zero_in[0]) || (m_zs == 2 && zero_in[1]);
      zero   = swz || hwz || srst;
      rd_out = reg_rd && reg_addr == 2;
      rd_cur = reg_rd && reg_addr == 3;
      harvest = trig_in || rd_cur;
      clr = (reg_wr && reg_addr == 1) ? reg_wdata[3:0] : 4'd0;
      set = {harvest && m_cov, harvest && m_sov, trig_in && m_pend && !rd_out, trig_in};
      if (reg_wr && reg_addr == 0) begin
         m_ie = reg_wdata[0]; m_de = reg_wdata[1]; m_ee = reg_wdata[2]; m_zs = reg_wdata[6:5];
      end
      if (srst) begin
         m_out = 0; m_curcnt = 0; m_st = 0; m_dma = 0; m_pend = 0;
      end else begin
         // dma uses enable as it stood before this edge
         if (trig_in && ((reg_wr && reg_addr == 0) ? dut_prev_de : m_de)) m_dma = 1;
         else if (dma_ack || rd_out) m_dma = 0;
         if (trig_in) begin m_out = m_acc; m_pend = 1; end
         else if (rd_out) m_pend = 0;
         if (rd_cur) m_curcnt = m_cnt;
         m_st = (m_st & ~clr) | set;
      end
      if (zero) begin
         m_acc = 0; m_cnt = 0; m_sov = 0; m_cov = 0;
      end else if (smp_vld) begin
         full = longint'(m_acc) + longint'($signed(smp_data));
         if (full > 64'sd2147483647 || full < -64'sd2147483648) m_sov = 1;
         m_acc = int'(full[31:0]);
         if (m_cnt == 16'hFFFF) m_cov = 1;
         m_cnt = m_cnt + 16'd1;
      end
      dut_prev_de = m_de;
   endfunction

   bit dut_prev_de;

   task automatic idle_inputs();
      smp_vld = 0; smp_data = '0; trig_in = 0; zero_in = '0; dma_ack = 0;
      reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
   endtask

   // one clock: inputs already driven at a negedge
   task automatic cycle();
      #1;
      if (reg_rd) check(addr_tag(reg_addr), reg_rdata, exp_rdata(reg_addr));
      model_step();
      @(posedge clk);
      @(negedge clk);
      check("R2 irq_update", irq_update, m_st[0] && m_ie);
      check("R3 irq_error", irq_error, m_st[1] && m_ee);
      check("R4 dma_req", dma_req, m_dma);
      idle_inputs();
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; cycle();
   endtask
   task automatic rd(input logic [2:0] a);
      reg_rd = 1; reg_addr = a; cycle();
   endtask
   task automatic smp(input logic [SW-1:0] v);
      smp_vld = 1; smp_data = v; cycle();
   endtask
   task automatic trg();
      trig_in = 1; cycle();
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      m_acc = 0; m_cnt = 0; m_curcnt = 0; m_sov = 0; m_cov = 0; m_pend = 0;
      m_dma = 0; m_out = 0; m_st = 0; m_ie = 0; m_de = 0; m_ee = 0; m_zs = 0;
      dut_prev_de = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state of every register
      for (int a = 0; a < 5; a++) rd(3'(a));

      // R1 R5 R7: stale count after zero, then coherent count
      phase = "R5 stale count";
      smp(24'd10); smp(24'hFFFFF0); smp(24'd7);
      rd(3); rd(4);
      wr(0, 32'h8);                         // R7 zero command
      rd(4);                                // still 3
      rd(0);                                // R7 zero bit reads 0
      smp(24'd1); smp(24'd2); smp(24'd3);
      rd(3); rd(4);                         // 3 samples since zero
      smp_vld = 1; smp_data = 24'd5; reg_rd = 1; reg_addr = 3; cycle(); // sample with read
      rd(4); rd(3);
      smp_vld = 1; smp_data = 24'd9; reg_wr = 1; reg_wdata = 32'h8; cycle(); // R7 sample dropped
      rd(3);

      // R2 R3 R4 updates, overruns, DMA
      phase = "R3 trig vs read";
      wr(0, 32'h7);
      smp(24'd100); trg(); rd(1);
      for (int i = 0; i < 8; i++) begin
         smp(24'(i));
         trig_in = 1; reg_rd = 1; reg_addr = 2; cycle();   // R3 no overrun
      end
      rd(1);
      trg();                                // R3 overrun
      rd(1); dma_ack = 1; cycle();          // R4 ack clears
      trg(); trig_in = 1; dma_ack = 1; cycle(); // R4 set wins
      rd(2);
      wr(1, 32'hF); rd(1);                  // R10 clear
      trig_in = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h1; cycle(); // R10 set wins
      rd(1);

      // R8 hardware zero select
      phase = "R8 hw zero";
      wr(0, 32'h0);
      smp(24'd55); zero_in = 2'b11; cycle(); rd(3);   // disabled: kept
      wr(0, 32'h40);                                  // select source 2
      zero_in = 2'b01; cycle(); rd(3);                // unselected: kept
      zero_in = 2'b10; cycle(); rd(3); rd(4);         // selected: zeroed
      wr(0, 32'h20); smp(24'd4); zero_in = 2'b01; smp_vld = 1; smp_data = 24'd8; cycle(); rd(3);

      // R6 signed overflow and sticky harvest
      phase = "R6 signed overflow";
      wr(0, 32'h8);
      for (int i = 0; i < 300; i++) smp(24'h7FFFFF);
      rd(1);                                // not yet sticky
      rd(3); rd(1);                         // harvested by the read
      wr(0, 32'h8); rd(1);                  // zero keeps sticky bit
      for (int i = 0; i < 300; i++) smp(24'h800000);
      trg(); rd(1); rd(2);

      // R6 count wrap
      phase = "R6 count wrap";
      wr(1, 32'hF); wr(0, 32'h8);
      for (int i = 0; i < 65537; i++) smp(24'd0);
      rd(1); rd(3); rd(4); rd(1);

      // R9 soft reset
      phase = "R9 soft reset";
      wr(0, 32'h3); smp(24'd6); trg(); rd(3);
      wr(0, 32'h12);
      for (int a = 0; a < 5; a++) rd(3'(a));

      // random mix of all functions
      phase = "R1 random";
      for (int i = 0; i < 4000; i++) begin
         smp_vld  = ($urandom_range(0, 1) == 1);
         smp_data = 24'($urandom());
         trig_in  = ($urandom_range(0, 7) == 0);
         dma_ack  = ($urandom_range(0, 7) == 0);
         zero_in  = ($urandom_range(0, 31) == 0) ? 2'($urandom()) : 2'b00;
         case ($urandom_range(0, 9))
            0: begin reg_wr = 1; reg_addr = 0;
                  reg_wdata = {25'd0, 2'($urandom()), 1'b0, ($urandom_range(0,15) == 0), 3'($urandom())};
               end
            1: begin reg_wr = 1; reg_addr = 1; reg_wdata = 32'($urandom_range(0, 15)); end
            2, 3, 4, 5: begin reg_rd = 1; reg_addr = 3'($urandom_range(0, 5)); end
            default: ;
         endcase
         cycle();
      end
      for (int a = 0; a < 5; a++) rd(3'(a));

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule